// File: doc/BRIEF.md
# No-Turnaround Pipelined SRAM Core

This block is a synchronous single-port memory with byte lanes. It accepts one command on every clock edge: a read, a write or a deselect. Write data trails its address by two enabled edges, and read data comes out of an output register one edge after the command. A read followed by a write, or a write followed by a read, therefore needs no idle cycle on the shared data bus. A host streams commands back to back. It either loads a fresh address or advances a four-beat burst whose low address bits step in linear or interleaved order.

A clock-enable input freezes the whole block. A sleep request stops it two edges after it rises and restarts it two edges after it falls, and the memory contents survive. Output data is presented together with a drive-enable flag, which stands for the bus driver being on. The flag is low whenever the output enable is high, no valid read result is held, or the block is asleep.

Top module: `ntsram_core`

## Requirements
- R1: A new command is loaded at an edge only when `cke_n` is low, `adv` is low and the block is selected (`cs1_n` low, `cs2` high, `cs3_n` low). With `adv` low and any select inactive the edge is a deselect, and no read result is produced for it.
- R2: A read commanded at edge E loads its word into the output register at edge E+1. `dout_en` is then high while `oe_n` is low. With `oe_n` high the read is a dummy, and `dout_en` stays low.
- R3: A write commanded at edge E takes `din` at the second enabled edge after E. A low bit i of `bw_n`, sampled with the command, updates only bits `[8i+7:8i]` of the word.
- R4: A write beat with every bit of `bw_n` high leaves the memory word unchanged.
- R5: A read returns the memory as left by every write commanded before it. This includes a write whose data beat arrives on the same edge as the read's array access.
- R6: With `adv` high after a read or write, the next beat uses the next burst address and the chip selects are ignored. The upper address bits stay at the start address. The low two bits are start XOR n when `burst_ilv` is high, and (start + n) mod 4 when it is low. n counts 1, 2, 3 and then wraps to 0.
- R7: `adv` high after a deselect is itself a deselect: nothing is written and no read result is produced.
- R8: While `cke_n` is high, all other synchronous inputs are ignored. The output register, the burst state and any pending write data beat all hold their values.
- R9: After `sleep` is sampled high at edge k, edges k and k+1 still execute and later edges are ignored, with `dout_en` low. After `sleep` is sampled low at edge m, edges m and m+1 are still ignored and edge m+2 executes. Memory contents survive sleep.
- R10: The synchronous reset `rst` leaves `dout_en` low after its edge. It cancels pending commands and ends any burst, so a following `adv` high is a deselect. It does not clear the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | High: advance burst; low: load new command |
| we_n | input | 1 | Low: write command; high: read command |
| bw_n | input | LANES | Byte-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Burst order: high interleaved, low linear |
| din | input | LANES*LANE_W | Write data, taken two enabled edges after its command |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| sleep | input | 1 | Sleep request, active high |
| dout | output | LANES*LANE_W | Output data register |
| dout_en | output | 1 | Output drive enable (low means high impedance) |

## Verification
The bench keeps its own picture of the memory and of the burst state. Every read therefore has a known word, which is compared two cycles after the command is issued. A burst counter that steps wrongly, or a select that is honoured during a burst, shows up as wrong data on the next read beat or on a later read of the stray address. A write beat taken one edge too early or too late, or a missing bypass of a just-arriving data beat, corrupts a word. The first read of that word after the fault reveals it, and the bench reads right after writing to catch it within two or three cycles. A freeze or sleep window that is one edge too long or too short drops or adds a command, which changes `dout_en` within two cycles of the window's end.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;
endpackage

// File: rtl/ntsram_burst.sv
// Burst address generator: holds the start address and a 2-bit beat count.
module ntsram_burst #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              load,
   input  logic              advance,
   input  logic              ilv,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic [1:0]        cnt_nx;
   logic [1:0]        low_nx;

   assign cnt_nx = cnt_q + 2'd1;
   assign low_nx = ilv ? (base_q[1:0] ^ cnt_nx) : (base_q[1:0] + cnt_nx);
   assign addr_out = load ? addr_in : {base_q[ADDR_W-1:2], low_nx};

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (en) begin
         if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
         end else if (advance) begin
            cnt_q <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/ntsram_array.sv
// Storage: one memory per byte lane, written under its own strobe.
module ntsram_array #(
   parameter  int ADDR_W = 6,
   parameter  int LANES  = 4,
   parameter  int LANE_W = 8,
   localparam int DW     = LANES * LANE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANES-1:0]  wr_lane,
   input  logic [DW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_lane[l]) begin
            cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
         end
      end

      assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
   end
endmodule

// File: rtl/ntsram_rdstage.sv
// Output register with per-lane bypass of a data beat committed on the same edge.
module ntsram_rdstage #(
   parameter  int ADDR_W = 6,
   parameter  int LANES  = 4,
   parameter  int LANE_W = 8,
   localparam int DW     = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              load_rd,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DW-1:0]     arr_data,
   input  logic              fwd_wr,
   input  logic [ADDR_W-1:0] fwd_addr,
   input  logic [LANES-1:0]  fwd_lane,
   input  logic [DW-1:0]     fwd_data,
   output logic [DW-1:0]     q,
   output logic              q_valid
);
   logic          hit;
   logic [DW-1:0] merged;

   assign hit = fwd_wr && (fwd_addr == rd_addr);

   for (genvar l = 0; l < LANES; l++) begin : g_mux
      assign merged[l*LANE_W +: LANE_W] = (hit && fwd_lane[l])
                                          ? fwd_data[l*LANE_W +: LANE_W]
                                          : arr_data[l*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid <= 1'b0;
      end else if (en) begin
         q_valid <= load_rd;
         if (load_rd) begin
            q <= merged;
         end
      end
   end
endmodule

// File: rtl/ntsram_core.sv
module ntsram_core
   import ntsram_pkg::*;
#(
   parameter  int ADDR_W = 6,
   parameter  int LANES  = 4,
   parameter  int LANE_W = 8,
   localparam int DW     = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cke_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              adv,
   input  logic              we_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              burst_ilv,
   input  logic [DW-1:0]     din,
   input  logic              oe_n,
   input  logic              sleep,
   output logic [DW-1:0]     dout,
   output logic              dout_en
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ntsram_core: ADDR_W must cover the two burst bits");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("ntsram_core: LANES and LANE_W must be positive");
   end

   // Sleep request passes two flops; the second one freezes the block.
   logic [1:0] slp_q;
   logic       asleep;
   logic       en;

   assign asleep = slp_q[1];
   assign en     = !cke_n && !asleep;

   // Command decode
   logic              selected;
   logic              load;
   logic              advance;
   op_e               burst_op;
   op_e               new_op;
   logic [ADDR_W-1:0] cur_addr;

   assign selected = !cs1_n && cs2 && !cs3_n;
   assign load     = !adv && selected;
   assign advance  = adv && (burst_op != OP_IDLE);

   always_comb begin
      if (!adv) begin
         if (selected) new_op = we_n ? OP_RD : OP_WR;
         else          new_op = OP_IDLE;
      end else begin
         new_op = burst_op;
      end
   end

   ntsram_burst #(.ADDR_W(ADDR_W)) i_burst (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .load     (load),
      .advance  (advance),
      .ilv      (burst_ilv),
      .addr_in  (addr),
      .addr_out (cur_addr)
   );

   // Two command stages: the first feeds the array read, the second
   // meets its write data beat.
   op_e               s1_op, s2_op;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [LANES-1:0]  s1_lane, s2_lane;

   always_ff @(posedge clk) begin
      if (rst) begin
         slp_q    <= '0;
         burst_op <= OP_IDLE;
         s1_op    <= OP_IDLE;
         s2_op    <= OP_IDLE;
      end else begin
         slp_q <= {slp_q[0], sleep};
         if (en) begin
            burst_op <= new_op;
            s1_op    <= new_op;
            s2_op    <= s1_op;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         s1_addr <= cur_addr;
         s1_lane <= ~bw_n;
         s2_addr <= s1_addr;
         s2_lane <= s1_lane;
      end
   end

   logic          commit;
   logic [DW-1:0] arr_q;
   logic          q_valid;

   assign commit = en && (s2_op == OP_WR);

   ntsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
      .clk     (clk),
      .wr_en   (commit),
      .wr_addr (s2_addr),
      .wr_lane (s2_lane),
      .wr_data (din),
      .rd_addr (s1_addr),
      .rd_data (arr_q)
   );

   ntsram_rdstage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_rdstage (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .load_rd  (s1_op == OP_RD),
      .rd_addr  (s1_addr),
      .arr_data (arr_q),
      .fwd_wr   (s2_op == OP_WR),
      .fwd_addr (s2_addr),
      .fwd_lane (s2_lane),
      .fwd_data (din),
      .q        (dout),
      .q_valid  (q_valid)
   );

   assign dout_en = q_valid && !oe_n && !asleep;
endmodule

// File: rtl/ntsram_core_chk.sv
module ntsram_core_chk #(
   parameter  int LANES  = 4,
   parameter  int LANE_W = 8,
   localparam int DW     = LANES * LANE_W
) (
   input logic          clk,
   input logic          rst,
   input logic          cke_n,
   input logic          cs1_n,
   input logic          cs2,
   input logic          cs3_n,
   input logic          adv,
   input logic          oe_n,
   input logic          sleep,
   input logic [DW-1:0] dout,
   input logic          dout_en
);
   // R1: a deselect edge followed by an enabled edge leaves the bus undriven
   p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(!cke_n && !adv && !(!cs1_n && cs2 && !cs3_n), 2) && !$past(cke_n)
       && !$past(sleep, 3) && !$past(sleep, 4)) |-> !dout_en);

   // R8: output register holds across a frozen edge
   p_stall_hold_data_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(cke_n) && !$past(rst)) |-> $stable(dout));

   // R8: drive flag holds across a frozen edge when nothing asynchronous moved
   p_stall_hold_en_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(cke_n) && !$past(rst) && $stable(oe_n)
       && ($past(sleep, 2) == $past(sleep, 3))) |-> $stable(dout_en));

   // R9: a sustained sleep request keeps the bus undriven
   p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      (sleep && $past(sleep) && $past(sleep, 2)) |-> !dout_en);

   // R10: the edge after reset leaves the bus undriven
   p_reset_quiet_r10: assert property (@(posedge clk)
      $past(rst) |-> !dout_en);
endmodule

bind ntsram_core ntsram_core_chk #(.LANES(LANES), .LANE_W(LANE_W)) i_chk (
   .clk     (clk),
   .rst     (rst),
   .cke_n   (cke_n),
   .cs1_n   (cs1_n),
   .cs2     (cs2),
   .cs3_n   (cs3_n),
   .adv     (adv),
   .oe_n    (oe_n),
   .sleep   (sleep),
   .dout    (dout),
   .dout_en (dout_en)
);

// File: tb/test_ntsram_core.sv
module test_ntsram_core;
   localparam int AW    = 6;
   localparam int LN    = 4;
   localparam int LW    = 8;
   localparam int DW    = LN * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cke_n = 1'b0;
   logic          cs1_n = 1'b1;
   logic          cs2 = 1'b0;
   logic          cs3_n = 1'b1;
   logic          adv = 1'b0;
   logic          we_n = 1'b1;
   logic [LN-1:0] bw_n = '1;
   logic [AW-1:0] addr = '0;
   logic          burst_ilv = 1'b0;
   logic [DW-1:0] din = '0;
   logic          oe_n = 1'b0;
   logic          sleep = 1'b0;
   logic [DW-1:0] dout;
   logic          dout_en;

   always #5 clk = ~clk;

   ntsram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_ntsram_core (
      .clk(clk), .rst(rst), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
      .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr), .burst_ilv(burst_ilv),
      .din(din), .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;
   string req = "R10";

   // Bench picture of the block
   logic [DW-1:0] mdl [DEPTH];
   int            b_op = 0;          // 0 none, 1 read, 2 write
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = '0;
   int            c = 0;             // enabled edges issued
   bit            exp_rd [8];
   logic [DW-1:0] exp_dat [8];
   logic [DW-1:0] wd_sched [8];
   bit            oe_v = 0, ilv_v = 0, slp_v = 0;

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic sample_out(input bit frozen);
      int s;
      bit e;
      s = (c + 6) & 7;
      e = !frozen && exp_rd[s] && !oe_n;
      check(req, {31'd0, dout_en}, {31'd0, e});
      if (e) check(req, dout, exp_dat[s]);
   endtask

   task automatic drive_cs(input bit ok);
      if (ok) begin
         cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
      end else begin
         cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
         case ($urandom % 3)
            0:       cs1_n = 1'b1;
            1:       cs2   = 1'b0;
            default: cs3_n = 1'b1;
         endcase
      end
   endtask

   // One enabled edge with the given command; the bench predicts its effect.
   task automatic tick(input bit a_adv, input bit a_we_n, input bit a_cs_ok,
                       input logic [AW-1:0] a_addr, input logic [LN-1:0] a_bw_n);
      int            op;
      logic [AW-1:0] ea;
      logic [1:0]    low;
      logic [DW-1:0] d;
      @(negedge clk);
      sample_out(0);
      adv = a_adv; we_n = a_we_n; addr = a_addr; bw_n = a_bw_n;
      drive_cs(a_cs_ok);
      cke_n = 1'b0; oe_n = oe_v; burst_ilv = ilv_v; sleep = slp_v;
      din = wd_sched[c & 7];
      op = 0; ea = a_addr;
      if (!a_adv) begin
         if (a_cs_ok) begin
            b_op = a_we_n ? 1 : 2; b_base = a_addr; b_cnt = 2'd0;
         end else begin
            b_op = 0;
         end
         op = b_op;
      end else if (b_op != 0) begin
         b_cnt = b_cnt + 2'd1;
         low = ilv_v ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
         ea = {b_base[AW-1:2], low};
         op = b_op;
      end
      if (op == 2) begin
         d = $urandom;
         for (int l = 0; l < LN; l++)
            if (!a_bw_n[l]) mdl[ea][l*LW +: LW] = d[l*LW +: LW];
         wd_sched[(c + 2) & 7] = d;
      end
      exp_rd[c & 7]  = (op == 1);
      exp_dat[c & 7] = mdl[ea];
      c++;
   endtask

   // One ignored edge: clock enable high, or (frozen) sleeping with it low.
   task automatic stall(input bit frozen);
      @(negedge clk);
      sample_out(frozen);
      adv = $urandom; we_n = $urandom; addr = $urandom; bw_n = $urandom;
      drive_cs($urandom % 2 == 0);
      cke_n = !frozen; oe_n = oe_v; burst_ilv = ilv_v; sleep = slp_v;
      din = $urandom;
   endtask

   task automatic desel(input int n);
      for (int i = 0; i < n; i++) tick(0, 1, 0, '0, '1);
   endtask

   task automatic rd(input logic [AW-1:0] a);
      tick(0, 1, 1, a, '1);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         exp_rd[i] = 0; exp_dat[i] = '0; wd_sched[i] = '0;
      end
      repeat (5) @(negedge clk);
      // R10: reset state
      check("R10", {31'd0, dout_en}, '0);
      rst = 1'b0;

      // R3: fill every word with back-to-back full writes, then read it all
      req = "R3";
      for (int a = 0; a < DEPTH; a++) tick(0, 0, 1, a[AW-1:0], '0);
      desel(2);
      req = "R2";
      for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0]);
      desel(2);

      // R2: dummy reads with output enable high stay undriven
      oe_v = 1;
      for (int a = 0; a < 6; a++) rd(a[AW-1:0]);
      oe_v = 0;
      desel(3);

      // R1: each inactive select turns a load into a deselect
      req = "R1";
      for (int i = 0; i < 12; i++) tick(0, i % 2 == 0, 0, $urandom, '0);
      desel(2);
      for (int a = 0; a < 8; a++) rd(a[AW-1:0]);
      desel(2);

      // R3, R4: every strobe pattern on its own word
      req = "R4";
      for (int p = 0; p < 16; p++) tick(0, 0, 1, p[AW-1:0], p[LN-1:0]);
      desel(2);
      for (int p = 0; p < 16; p++) rd(p[AW-1:0]);
      desel(2);

      // R5: read right after a write with gaps of 0, 1 and 2 edges
      req = "R5";
      for (int g = 0; g < 3; g++) begin
         for (int k = 0; k < 8; k++) begin
            logic [AW-1:0] a;
            a = $urandom;
            tick(0, 0, 1, a, $urandom);
            desel(g);
            rd(a);
         end
         desel(2);
      end
      for (int k = 0; k < 16; k++) begin
         logic [AW-1:0] a;
         a = $urandom % 4;
         if ($urandom % 2 == 0) tick(0, 0, 1, a, $urandom); else rd(a);
      end
      desel(2);

      // R6: bursts from every start in both orders, six beats to show the wrap
      req = "R6";
      for (int m = 0; m < 2; m++) begin
         ilv_v = m[0];
         for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] base;
            base = {4'(4 + s), s[1:0]};
            rd(base);
            for (int b = 0; b < 5; b++) tick(1, 0, b % 2 == 0, '0, '0);
            tick(0, 0, 1, base, '0);
            for (int b = 0; b < 5; b++) tick(1, 1, 0, '0, $urandom);
            desel(2);
            for (int w = 0; w < 4; w++) rd({base[AW-1:2], w[1:0]});
            desel(2);
         end
      end
      ilv_v = 0;

      // R7: continue after a deselect writes nothing and reads nothing
      req = "R7";
      tick(0, 0, 1, 6'd40, '0);
      tick(1, 0, 1, '0, '0);
      desel(1);
      for (int b = 0; b < 3; b++) tick(1, 0, 1, '0, '0);
      desel(1);
      for (int b = 0; b < 3; b++) tick(1, 1, 1, '0, '0);
      desel(2);
      for (int w = 40; w < 44; w++) rd(w[AW-1:0]);
      desel(2);

      // R8: clock-enable freeze holds output, pending data and burst state
      req = "R8";
      rd(6'd9);
      desel(1);
      for (int i = 0; i < 3; i++) stall(0);
      tick(0, 0, 1, 6'd12, '0);
      stall(0);
      desel(1);
      stall(0); stall(0);
      desel(2);
      rd(6'd12);
      tick(0, 1, 1, 6'd21, '1);
      stall(0);
      tick(1, 1, 0, '0, '1);
      stall(0); stall(0);
      tick(1, 1, 1, '0, '1);
      tick(1, 1, 1, '0, '1);
      desel(2);

      // R9: sleep entry after two edges, exit after two edges, memory kept
      req = "R9";
      slp_v = 1;
      desel(2);
      for (int i = 0; i < 5; i++) stall(1);
      slp_v = 0;
      stall(1); stall(1);
      for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0]);
      desel(2);

      // R10: reset cancels a burst and keeps the memory
      req = "R10";
      rd(6'd30);
      @(negedge clk);
      rst = 1'b1; cke_n = 1'b0; adv = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R10", {31'd0, dout_en}, '0);
      for (int i = 0; i < 8; i++) exp_rd[i] = 0;
      b_op = 0;
      for (int b = 0; b < 3; b++) tick(1, 0, 1, '0, '0);
      desel(2);
      for (int a = 28; a < 36; a++) rd(a[AW-1:0]);
      desel(2);

      // R5, R6, R8: random mix of commands, orders, strobes and freezes
      req = "R5";
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 16 == 0) oe_v = !oe_v;
         if ($urandom % 8 == 0) ilv_v = !ilv_v;
         if ($urandom % 10 == 0) stall(0);
         else tick($urandom % 10 < 3, $urandom, $urandom % 8 != 0, $urandom,
                   ($urandom % 10 == 0) ? '1 : LN'($urandom));
      end
      oe_v = 0;
      desel(3);
      for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0]);
      desel(3);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule